// File: doc/BRIEF.md
# Per-Channel Oversampling Averager

This block sits behind a sampling converter and turns a stream of channel-tagged 12-bit samples into averaged results that carry extra resolution. For a selected ratio of 4^n samples (n from 1 to 4), it sums 4^n samples of a channel and shifts the sum right by n. The result therefore has 12+n significant bits in a 16-bit output word. When the ratio field is zero, every sample is passed straight through. Every channel keeps its own running sum and sample count, so samples from several channels may arrive interleaved in any order.

The block also generates conversion requests for the converter. In per-sample trigger mode each trigger event asks for exactly one conversion, so one average needs many triggers. In burst mode a single trigger keeps the request line asserted until an average completes, so all samples of one average are taken back to back. Each finished average raises a one-cycle ready strobe. The result word and its channel number are held on the outputs. If an average finishes while the previous result has not been acknowledged, a sticky overrun bit is set for the channel of the new result.

Top module: `osr_averager`

## Requirements
- R1: After reset, res_ready, res_data, res_ch, overrun and conv_req are all zero.
- R2: With rate 0, each accepted sample appears on res_data (zero-extended) with its channel on res_ch, and res_ready is high in the cycle after the sample is presented.
- R3: With rate n in 1..4, the 4^n-th accepted sample of a channel completes its average: res_data equals the sum of those 4^n samples shifted right by n. No result is produced for that channel on the earlier samples.
- R4: Accumulation is per channel: interleaved samples of different channels give each channel the average of its own samples only.
- R5: Rate values 5, 6 and 7 behave as rate 4 (ratio 256, shift 4).
- R6: A change of the effective rate clears every accumulator, every sample count and all overrun bits. A sample presented in the same cycle as the change is discarded.
- R7: res_ready is high for exactly one cycle per completed result. res_data and res_ch keep their values until the next result.
- R8: A result that completes while the previous result is still unacknowledged (res_ack low) sets overrun bit c, where c is the channel of the new result. Overrun bits stay set until a rate change or a reset.
- R9: With single_trig at 0 (per-sample mode) and no burst in progress, conv_req follows trig in the same cycle.
- R10: With single_trig at 1 and a nonzero rate, a trig pulse holds conv_req high from the next cycle until the cycle after an average completes. The clock edge on which that average completes is the one that drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate | input | 3 | Ratio select: 0 pass-through, n gives 4^n samples; values above 4 act as 4 |
| single_trig | input | 1 | 1: one trigger runs a whole average as a burst; 0: one sample per trigger |
| trig | input | 1 | Trigger event |
| conv_req | output | 1 | Conversion request toward the converter |
| smp_valid | input | 1 | Sample strobe |
| smp_ch | input | 3 | Channel number of the sample |
| smp_data | input | 12 | Sample value |
| res_ack | input | 1 | Current result has been taken |
| res_ready | output | 1 | One-cycle strobe: a new result is on res_data |
| res_data | output | 16 | Averaged (or passed-through) result |
| res_ch | output | 5 | Channel number of the result |
| overrun | output | 8 | Sticky per-channel overrun bits |

## Verification
The bench builds the block with its default parameters: eight channels, 12-bit samples and a maximum rate of 4. The largest ratio is therefore 256 samples, which lets a single run cover every ratio end to end, including a full-scale 256-sample average that reaches the top of the 16-bit range. Eight channels at ratio 16 need only 128 interleaved samples, so the bench can check every channel's average against its own arithmetic sum. The rate-change, overrun and burst-request sequences each run over a few dozen cycles.

// File: rtl/osr_pkg.sv
package osr_pkg;
   // how trigger events map onto conversion requests
   typedef enum logic {
      TRIG_EACH  = 1'b0,   // one conversion per trigger
      TRIG_BURST = 1'b1    // one trigger runs a whole average
   } osr_trig_mode_e;

   // number of samples folded into one average for a given rate code
   function automatic int unsigned osr_ratio(input int unsigned code);
      return 32'd1 << (2 * code);
   endfunction
endpackage

// File: rtl/osr_chan_acc.sv
module osr_chan_acc #(
   parameter int SAMPLE_W = 12,
   parameter int MAX_RATE = 4,
   parameter int RATE_W   = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         hit,
   input  logic [RATE_W-1:0]            shift,
   input  logic [SAMPLE_W-1:0]          sample,
   output logic                         done,
   output logic [SAMPLE_W+MAX_RATE-1:0] avg
);
   localparam int ACC_W = SAMPLE_W + 2 * MAX_RATE;
   localparam int CNT_W = 2 * MAX_RATE;
   localparam int AVG_W = SAMPLE_W + MAX_RATE;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] sum;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   always_comb begin
      lim  = CNT_W'(osr_pkg::osr_ratio(32'(shift)) - 32'd1);
      sum  = acc + ACC_W'(sample);
      done = hit && (cnt == lim);
      avg  = AVG_W'(sum >> shift);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         cnt <= '0;
      end else if (clear) begin
         acc <= '0;
         cnt <= '0;
      end else if (hit) begin
         if (cnt == lim) begin
            acc <= '0;
            cnt <= '0;
         end else begin
            acc <= sum;
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R3: the sample count never runs past the ratio in force
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
   // R3: a completed average restarts its channel from zero
   a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !clear) |=> (cnt == '0 && acc == '0));
endmodule

// File: rtl/osr_trig_seq.sv
module osr_trig_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic trig,
   input  logic single_trig,
   input  logic rate_nz,
   input  logic done_any,
   output logic conv_req
);
   import osr_pkg::*;

   osr_trig_mode_e mode;
   logic           burst_q;

   assign mode     = osr_trig_mode_e'(single_trig);
   assign conv_req = trig || burst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         burst_q <= 1'b0;
      else if (clear)
         burst_q <= 1'b0;
      else if (trig && mode == TRIG_BURST && rate_nz)
         burst_q <= 1'b1;
      else if (done_any)
         burst_q <= 1'b0;
   end

   // R10: a burst trigger keeps requests flowing on the next cycle
   a_r10_burst_start: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && single_trig && rate_nz && !clear) |=> conv_req);
   // R10: an open burst with no completion stays open
   a_r10_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_q && !done_any && !clear) |=> conv_req);
endmodule

// File: rtl/osr_averager.sv
module osr_averager #(
   parameter int NUM_CH   = 8,
   parameter int SAMPLE_W = 12,
   parameter int RESULT_W = 16,
   parameter int MAX_RATE = 4,
   parameter int RATE_W   = 3,
   parameter int CH_OUT_W = 5,
   parameter int CH_IN_W  = $clog2(NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RATE_W-1:0]   rate,
   input  logic                single_trig,
   input  logic                trig,
   output logic                conv_req,
   input  logic                smp_valid,
   input  logic [CH_IN_W-1:0]  smp_ch,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                res_ack,
   output logic                res_ready,
   output logic [RESULT_W-1:0] res_data,
   output logic [CH_OUT_W-1:0] res_ch,
   output logic [NUM_CH-1:0]   overrun
);
   localparam int AVG_W = SAMPLE_W + MAX_RATE;

   generate
      if (NUM_CH < 2 || NUM_CH > (1 << CH_OUT_W))
         $error("NUM_CH must lie in 2..2**CH_OUT_W");
      if (MAX_RATE < 1 || MAX_RATE >= (1 << RATE_W))
         $error("MAX_RATE must be encodable in RATE_W bits");
      if (RESULT_W < AVG_W)
         $error("RESULT_W too narrow for SAMPLE_W + MAX_RATE");
   endgenerate

   logic [RATE_W-1:0] rate_eff;
   logic [RATE_W-1:0] rate_q;
   logic              clear;
   logic [NUM_CH-1:0] done;
   logic [AVG_W-1:0]  avg_arr [NUM_CH];
   logic [AVG_W-1:0]  sel_avg;
   logic              done_any;
   logic              res_full;

   assign rate_eff = (rate > RATE_W'(MAX_RATE)) ? RATE_W'(MAX_RATE) : rate;
   assign clear    = (rate_eff != rate_q);
   assign done_any = |done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rate_q <= '0;
      else        rate_q <= rate_eff;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      osr_chan_acc #(
         .SAMPLE_W (SAMPLE_W),
         .MAX_RATE (MAX_RATE),
         .RATE_W   (RATE_W)
      ) u_acc (
         .clk    (clk),
         .rst_n  (rst_n),
         .clear  (clear),
         .hit    (smp_valid && !clear && smp_ch == CH_IN_W'(i)),
         .shift  (rate_q),
         .sample (smp_data),
         .done   (done[i]),
         .avg    (avg_arr[i])
      );
   end

   always_comb begin
      sel_avg = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (done[i]) sel_avg = sel_avg | avg_arr[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_ready <= 1'b0;
         res_data  <= '0;
         res_ch    <= '0;
         res_full  <= 1'b0;
         overrun   <= '0;
      end else begin
         res_ready <= done_any;
         if (done_any) begin
            res_data <= RESULT_W'(sel_avg);
            res_ch   <= CH_OUT_W'(smp_ch);
         end
         if (clear) begin
            res_full <= 1'b0;
            overrun  <= '0;
         end else begin
            if (done_any)     res_full <= 1'b1;
            else if (res_ack) res_full <= 1'b0;
            for (int i = 0; i < NUM_CH; i++)
               if (done[i] && res_full && !res_ack) overrun[i] <= 1'b1;
         end
      end
   end

   osr_trig_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .trig        (trig),
      .single_trig (single_trig),
      .rate_nz     (rate_q != '0),
      .done_any    (done_any),
      .conv_req    (conv_req)
   );

   // R4: a sample belongs to one channel, so at most one average ends per cycle
   a_r4_one_done: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done));
   // R7: every ready strobe follows an accepted sample
   a_r7_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready |-> $past(smp_valid));
   // R2: pass-through returns the raw sample one cycle later
   a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == '0 && !clear && smp_valid && 32'(smp_ch) < NUM_CH)
      |=> (res_ready && res_data == RESULT_W'($past(smp_data))));
   // R8: overrun bits are only ever removed by a rate change
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((overrun & $past(overrun)) == $past(overrun)));
endmodule

// File: tb/osr_averager_test.sv
module osr_averager_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  rate = '0;
   logic        single_trig = 1'b0;
   logic        trig = 1'b0;
   logic        conv_req;
   logic        smp_valid = 1'b0;
   logic [2:0]  smp_ch = '0;
   logic [11:0] smp_data = '0;
   logic        res_ack = 1'b1;
   logic        res_ready;
   logic [15:0] res_data;
   logic [4:0]  res_ch;
   logic [7:0]  overrun;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   osr_averager uut (
      .clk(clk), .rst_n(rst_n), .rate(rate), .single_trig(single_trig),
      .trig(trig), .conv_req(conv_req), .smp_valid(smp_valid),
      .smp_ch(smp_ch), .smp_data(smp_data), .res_ack(res_ack),
      .res_ready(res_ready), .res_data(res_data), .res_ch(res_ch),
      .overrun(overrun)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive a sample at a falling edge, return at the next falling edge
   task automatic send(input int ch, input int val);
      smp_valid = 1'b1;
      smp_ch    = 3'(ch);
      smp_data  = 12'(val);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic set_rate(input int r);
      rate = 3'(r);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      #35;
      // R1 reset state
      check("R1 res_ready", res_ready, 0);
      check("R1 res_data", res_data, 0);
      check("R1 res_ch", res_ch, 0);
      check("R1 overrun", overrun, 0);
      check("R1 conv_req", conv_req, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 pass-through sweep over channels and values
      for (int i = 0; i < 66; i++) begin
         int v;
         v = (i == 64) ? 4095 : (i == 65) ? 0 : ((i * 67 + 5) & 4095);
         send(i % 8, v);
         check("R2 ready", res_ready, 1);
         check("R2 data", res_data, v);
         check("R2 channel", res_ch, i % 8);
      end

      // R7 strobe drops while data holds
      @(negedge clk);
      check("R7 ready low", res_ready, 0);
      check("R7 data held", res_data, 0);
      check("R7 channel held", res_ch, 1);

      // R8 overrun on unacknowledged result
      res_ack = 1'b0;
      send(3, 11);
      check("R8 no overrun on first", overrun, 0);
      send(5, 22);
      check("R8 overrun bit of channel 5", overrun, 8'h20);
      res_ack = 1'b1;
      send(2, 33);
      check("R8 overrun sticky", overrun, 8'h20);

      // R6 rate change clears sums and overrun; same-cycle sample dropped
      set_rate(1);
      check("R6 overrun cleared", overrun, 0);
      send(0, 100);
      send(0, 200);
      rate = 3'd2;
      send(0, 999);
      for (int k = 0; k < 15; k++) begin
         send(0, 10);
         check("R6 no early result", res_ready, 0);
      end
      send(0, 10);
      check("R6 ready", res_ready, 1);
      check("R6 fresh average", res_data, 40);

      // R3 every ratio, one channel
      for (int r = 1; r <= 4; r++) begin
         int n;
         int early;
         longint sum;
         set_rate(r);
         n = 1 << (2 * r);
         sum = 0;
         early = 0;
         for (int k = 0; k < n; k++) begin
            int v;
            v = (r == 4) ? 4095 : ((k * 373 + r * 41) & 4095);
            sum += v;
            send(6, v);
            if (k < n - 1 && res_ready) early++;
         end
         check("R3 no early result", early, 0);
         check("R3 ready", res_ready, 1);
         check("R3 average", res_data, sum >> r);
         check("R3 channel", res_ch, 6);
      end

      // R5 code 7 acts as ratio 256, shift 4
      set_rate(7);
      begin
         int early;
         early = 0;
         for (int k = 0; k < 256; k++) begin
            send(1, (k & 1) ? 3 : 1);
            if (k < 255 && res_ready) early++;
         end
         check("R5 no early result", early, 0);
         check("R5 average", res_data, 512 >> 4);
      end

      // R4 interleaved channels at ratio 16
      set_rate(2);
      for (int k = 0; k < 16; k++)
         for (int c = 0; c < 8; c++) begin
            send(c, (c * 500 + k * 29) & 4095);
            if (k == 15) begin
               longint s;
               s = 0;
               for (int j = 0; j < 16; j++) s += (c * 500 + j * 29) & 4095;
               check("R4 ready", res_ready, 1);
               check("R4 average", res_data, s >> 2);
               check("R4 channel", res_ch, c);
            end else begin
               check("R4 no early result", res_ready, 0);
            end
         end

      // R9 per-sample mode: request follows trigger
      single_trig = 1'b0;
      trig = 1'b1;
      #1 check("R9 request with trigger", conv_req, 1);
      @(negedge clk);
      trig = 1'b0;
      #1 check("R9 request drops", conv_req, 0);
      @(negedge clk);

      // R10 burst mode at ratio 4
      set_rate(1);
      single_trig = 1'b1;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      #1 check("R10 burst request", conv_req, 1);
      for (int k = 0; k < 3; k++) begin
         send(2, 7);
         check("R10 burst held", conv_req, 1);
      end
      send(2, 7);
      check("R10 burst result", res_data, 14);
      check("R10 burst ends", conv_req, 0);

      finish_run();
   end
endmodule